// File: doc/BRIEF.md
# Dual-Direction Storing Bus Transceiver

This block carries an 18-bit word between two sides, A and B. Each direction has its own storage stage and its own control set, so A-to-B traffic and B-to-A traffic never interact. One storage stage can pass data straight through, hold a captured word, or capture a new word on a rising edge of a per-direction path clock. A clock-enable input can suppress that capture. The path is transparent while its latch enable is high. While latch enable is low, it holds its word until a permitted clock edge loads a new one.

The whole block runs on one system clock. Each path clock is an ordinary sampled input. A rising edge is a low sample followed by a high sample on consecutive system cycles. Every output is a data bus paired with a drive-enable flag, which stands in for a three-state pin. The output enable is active low. It affects only the drive-enable flag and never the stored word.

Top module: `bus_xcvr`

## Requirements
- R1: While reset (rstN low) is asserted, and after it is released, each direction's stored word is zero. With latch enable low, each output data bus reads zero until a load occurs.
- R2: When a direction's latch enable is high, its output data equals its source-side input in the same system cycle.
- R3: When latch enable is low and no permitted rising path-clock edge is sampled, the output data stays unchanged. This holds while the path clock stays high, while it stays low, and while the source data changes.
- R4: When latch enable is low and the path clock is sampled low in one system cycle and high in the next, the source data present in that second cycle is stored, provided clock enable is low. The stored word appears on the output from the following system cycle.
- R5: While the active-low clock enable is high, a rising path-clock edge loads nothing and the output keeps its previous value.
- R6: The drive-enable output is high exactly while the active-low output enable is low. Toggling output enable leaves the output data bus unchanged.
- R7: When latch enable falls, storage keeps the last word that was passed through while transparent.
- R8: The B-to-A direction follows R1 to R7 with its own controls. Activity in one direction never changes the other direction's outputs.
- R9: While latch enable is high, a rising path-clock edge has no effect different from transparency. After latch enable falls, the output shows the last transparent word.
- R10: Immediately after reset is released, a path clock that is already high does not count as a rising edge. An edge needs a low sample first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| abOeN | input | 1 | A-to-B output enable, active low |
| abLatchEn | input | 1 | A-to-B latch enable, high = transparent |
| abClk | input | 1 | A-to-B path clock, sampled |
| abClkEnN | input | 1 | A-to-B clock enable, active low |
| aIn | input | 18 | A-side data into the A-to-B path |
| bOut | output | 18 | B-side data from the A-to-B path |
| bDrive | output | 1 | B-side drive enable |
| baOeN | input | 1 | B-to-A output enable, active low |
| baLatchEn | input | 1 | B-to-A latch enable, high = transparent |
| baClk | input | 1 | B-to-A path clock, sampled |
| baClkEnN | input | 1 | B-to-A clock enable, active low |
| bIn | input | 18 | B-side data into the B-to-A path |
| aOut | output | 18 | A-side data from the B-to-A path |
| aDrive | output | 1 | A-side drive enable |

## Verification
A corrupted stored word stays hidden while latch enable is high. It shows up on the output data bus in the first cycle after latch enable falls, or in the cycle after a load that should have happened. A wrong previous-clock sample shows as a missed capture or a false capture: the output diverges one cycle after the bad edge decision and stays wrong until the next load. The bench runs a behavioural model of both directions and compares every output on every cycle. Any stored-state error therefore surfaces within one cycle of becoming visible.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic pass;
    logic load;
  } laneStrobe_t;
endpackage

// File: rtl/xcvr_lane_ctrl.sv
module xcvr_lane_ctrl
  import xcvr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        latchEn,
  input  logic        pathClk,
  input  logic        clkEnN,
  output laneStrobe_t strobe
);
  logic prevClk;
  logic rise;

  // previous sample resets high so a clock already high after reset is no edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevClk <= 1'b1;
    else       prevClk <= pathClk;
  end

  assign rise = pathClk & ~prevClk;

  always_comb begin
    strobe.pass = latchEn;
    strobe.load = ~latchEn & rise & ~clkEnN;
  end

  // R4: a load needs a low sample first, so two loads never come back to back
  p_single_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !strobe.load);
endmodule

// File: rtl/xcvr_lane_dp.sv
module xcvr_lane_dp
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  laneStrobe_t      strobe,
  input  logic             oeN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             driveEn
);
  logic [WIDTH-1:0] store;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           store <= '0;
    else if (strobe.pass || strobe.load) store <= dataIn;
  end

  assign dataOut = strobe.pass ? dataIn : store;
  assign driveEn = ~oeN;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pass && !strobe.load) |=> (strobe.pass || $stable(dataOut)));

  p_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (strobe.pass || dataOut == $past(dataIn)));

  p_fall_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pass |=> (strobe.pass || dataOut == $past(dataIn)));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oeN,
  input  logic             latchEn,
  input  logic             pathClk,
  input  logic             clkEnN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             driveEn
);
  laneStrobe_t strobe;

  xcvr_lane_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .latchEn(latchEn),
    .pathClk(pathClk), .clkEnN(clkEnN), .strobe(strobe)
  );

  xcvr_lane_dp #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .oeN(oeN),
    .dataIn(dataIn), .dataOut(dataOut), .driveEn(driveEn)
  );

  p_transparent_r2: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |-> dataOut == dataIn);

  p_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clkEnN && !latchEn) |=> (latchEn || $stable(dataOut)));
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             abOeN,
  input  logic             abLatchEn,
  input  logic             abClk,
  input  logic             abClkEnN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive,
  input  logic             baOeN,
  input  logic             baLatchEn,
  input  logic             baClk,
  input  logic             baClkEnN,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive
);
  xcvr_lane #(.WIDTH(WIDTH)) abLane_i (
    .clk(clk), .rstN(rstN), .oeN(abOeN), .latchEn(abLatchEn),
    .pathClk(abClk), .clkEnN(abClkEnN), .dataIn(aIn),
    .dataOut(bOut), .driveEn(bDrive)
  );

  xcvr_lane #(.WIDTH(WIDTH)) baLane_i (
    .clk(clk), .rstN(rstN), .oeN(baOeN), .latchEn(baLatchEn),
    .pathClk(baClk), .clkEnN(baClkEnN), .dataIn(bIn),
    .dataOut(aOut), .driveEn(aDrive)
  );
endmodule

// File: tb/bus_xcvr_tb_top.sv
module bus_xcvr_tb_top;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic abOeN = 1'b1, abLatchEn = 1'b0, abClk = 1'b0, abClkEnN = 1'b0;
  logic baOeN = 1'b1, baLatchEn = 1'b0, baClk = 1'b0, baClkEnN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] bOut, aOut;
  logic bDrive, aDrive;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  string tag = "R1";

  logic [W-1:0] mStore [2];
  bit mPrev [2];

  always #4 clk = ~clk;

  bus_xcvr #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN),
    .abOeN(abOeN), .abLatchEn(abLatchEn), .abClk(abClk), .abClkEnN(abClkEnN),
    .aIn(aIn), .bOut(bOut), .bDrive(bDrive),
    .baOeN(baOeN), .baLatchEn(baLatchEn), .baClk(baClk), .baClkEnN(baClkEnN),
    .bIn(bIn), .aOut(aOut), .aDrive(aDrive)
  );

  task automatic chkVal(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic modelUpdate();
    bit le [2], pc [2], ce [2];
    logic [W-1:0] di [2];
    le[0] = abLatchEn; pc[0] = abClk; ce[0] = abClkEnN; di[0] = aIn;
    le[1] = baLatchEn; pc[1] = baClk; ce[1] = baClkEnN; di[1] = bIn;
    for (int d = 0; d < 2; d++) begin
      if (!rstN) begin
        mStore[d] = '0;
        mPrev[d] = 1'b1;
      end else begin
        if (le[d] || (pc[d] && !mPrev[d] && !ce[d])) mStore[d] = di[d];
        mPrev[d] = pc[d];
      end
    end
  endtask

  task automatic compareAll();
    string tagB;
    tagB = {tag, "/R8"};
    chkVal(tag, bOut, abLatchEn ? aIn : mStore[0]);
    chkVal({tag, "/R6"}, {{(W-1){1'b0}}, bDrive}, {{(W-1){1'b0}}, ~abOeN});
    chkVal(tagB, aOut, baLatchEn ? bIn : mStore[1]);
    chkVal({tagB, "/R6"}, {{(W-1){1'b0}}, aDrive}, {{(W-1){1'b0}}, ~baOeN});
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelUpdate();
      @(negedge clk);
      compareAll();
    end
  endtask

  initial begin
    mStore[0] = '0; mStore[1] = '0; mPrev[0] = 1'b1; mPrev[1] = 1'b1;
    // R1: reset, with edges offered during reset
    tag = "R1";
    aIn = 18'h2A5A5; bIn = 18'h15A5A;
    tick(1);
    abClk = 1'b1; baClk = 1'b1;
    tick(2);
    rstN = 1'b1;
    // R10: clock already high after reset is not an edge
    tag = "R10";
    tick(3);
    chkVal("R1", bOut, '0);
    chkVal("R1", aOut, '0);
    abClk = 1'b0; baClk = 1'b0;
    tick(1);

    // R2: transparent
    tag = "R2";
    abLatchEn = 1'b1; abOeN = 1'b0;
    for (int k = 0; k < 4; k++) begin
      aIn = 18'h01234 + 18'(k * 18'h0F0F1);
      tick(1);
      chkVal("R2", bOut, aIn);
    end
    // R7: fall keeps last transparent word
    tag = "R7";
    aIn = 18'h3C3C3;
    tick(1);
    abLatchEn = 1'b0;
    aIn = 18'h00001;
    tick(2);
    chkVal("R7", bOut, 18'h3C3C3);

    // R4: rising edge with clock enable low loads
    tag = "R4";
    aIn = 18'h12345;
    abClk = 1'b1;
    tick(1);
    aIn = 18'h0AAAA;
    tick(1);
    chkVal("R4", bOut, 18'h12345);

    // R3: clock held high, then low, data moving
    tag = "R3";
    for (int k = 0; k < 3; k++) begin aIn = 18'(k + 7); tick(1); end
    abClk = 1'b0;
    for (int k = 0; k < 3; k++) begin aIn = 18'(k + 70); tick(1); end
    chkVal("R3", bOut, 18'h12345);

    // R5: clock enable high blocks the edge
    tag = "R5";
    abClkEnN = 1'b1; aIn = 18'h3FFFF;
    abClk = 1'b1;
    tick(2);
    chkVal("R5", bOut, 18'h12345);
    abClk = 1'b0; abClkEnN = 1'b0;
    tick(1);

    // R9: edge during transparency
    tag = "R9";
    abLatchEn = 1'b1; aIn = 18'h2BEEF;
    abClk = 1'b1;
    tick(1);
    aIn = 18'h1CAFE;
    tick(1);
    abLatchEn = 1'b0; aIn = 18'h00000;
    tick(1);
    chkVal("R9", bOut, 18'h1CAFE);
    abClk = 1'b0;

    // R6: output enable toggling leaves data alone
    tag = "R6";
    abOeN = 1'b1; tick(1);
    chkVal("R6", {{(W-1){1'b0}}, bDrive}, '0);
    abOeN = 1'b0; tick(1);
    chkVal("R6", bOut, 18'h1CAFE);
    chkVal("R6", {{(W-1){1'b0}}, bDrive}, 18'h1);

    // R8: B-to-A direction alone, A-to-B must not move
    tag = "R8";
    baOeN = 1'b0; bIn = 18'h0F00F;
    baClk = 1'b1; tick(1);
    bIn = 18'h00000; tick(1);
    chkVal("R8", aOut, 18'h0F00F);
    chkVal("R8", bOut, 18'h1CAFE);
    baClk = 1'b0; tick(1);

    // mixed pseudo-random traffic on both directions
    tag = "R2,R3,R4,R5";
    for (int k = 0; k < 3000; k++) begin
      abLatchEn = ($urandom_range(0, 7) == 0);
      baLatchEn = ($urandom_range(0, 7) == 0);
      abClk = 1'($urandom); baClk = 1'($urandom);
      abClkEnN = ($urandom_range(0, 3) == 0);
      baClkEnN = ($urandom_range(0, 3) == 0);
      abOeN = 1'($urandom); baOeN = 1'($urandom);
      aIn = 18'($urandom); bIn = 18'($urandom);
      tick(1);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule